// File: doc/BRIEF.md
# Supply Brown-out and Power-up Access Guard

This block watches two digital supply comparator flags. One says the supply is under the switch threshold; the other says it is under the deeper reset level. From these flags the block decides when the memory array may be written and when an externally requested nonvolatile store may go ahead. It also raises a one-cycle power-fail store request as the supply sinks through the switch threshold. It latches a recall request whenever the supply has been under the reset level, and it launches that recall once the supply is back above the switch threshold.

Both comparator flags cross into the clock domain through a two-stage synchronizer. Chip enable and write enable are active-low strobes that are synchronous to the block clock. Once a recall has been launched, all access stays blocked until the recall engine reports completion. Reset counts as a power-up event, so the first action after reset is always a recall. A write strobe that is still held low when access returns is not trusted. It stays blocked until one of the two strobes goes high or shows a new falling edge.

Top module: `supply_guard`

## Requirements
- R1: While the synchronized below-switch flag is 1, or while a recall is latched or running, `ext_store_allow_o` and `write_allow_o` are both 0.
- R2: When `vcc_lo_sw_i` rises from 0 to 1, `pfail_store_o` is 1 for exactly one cycle, and that cycle follows the third rising clock edge after the change. No pulse follows reset release.
- R3: While the synchronized below-reset flag is 1, a recall is latched. `recall_req_o` stays 0 as long as the synchronized below-switch flag is 1.
- R4: A latched recall drives `recall_req_o` to 1 once the synchronized below-switch flag is 0. `recall_req_o` then stays 1 until `recall_done_i` is sampled 1. A dip under the switch threshold alone, with the reset level never reached, launches no recall.
- R5: `recall_done_i` sampled during a running recall clears `recall_req_o` and sets `ext_store_allow_o` after the same edge. `write_allow_o` follows one edge later, provided the strobes are not both low. `recall_done_i` has no effect while no recall runs.
- R6: If `ce_ni` and `we_ni` are both 0 when access is re-enabled, `write_allow_o` stays 0. It returns to 1 only after one strobe is seen high, or after a falling edge on either strobe, while access is enabled.
- R7: A rise of the below-reset flag during a running recall drops `recall_req_o` and re-latches the recall. The recall starts again once the supply is above the switch threshold.
- R8: After reset both synchronized flags read 1 and a recall is latched. With both flag inputs at 0, `recall_req_o` becomes 1 after the third rising edge following reset release and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vcc_lo_sw_i | input | 1 | Supply below switch threshold (asynchronous) |
| vcc_lo_rst_i | input | 1 | Supply below reset level (asynchronous) |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| recall_done_i | input | 1 | Recall engine reports completion |
| pfail_store_o | output | 1 | One-cycle power-fail store request |
| recall_req_o | output | 1 | Power-up recall request, held until done |
| write_allow_o | output | 1 | Array writes permitted |
| ext_store_allow_o | output | 1 | Externally initiated stores permitted |

## Verification
The hardest condition to reach from the ports is a supply dip below the reset level while a recall is already in flight. To get there, the stimulus first returns the supply, waits until `recall_req_o` is seen high, and only then raises both flags again, without ever pulsing `recall_done_i`. It then checks that the request drops, stays down while the supply is under the switch threshold, and comes back on recovery. A second awkward case is a write strobe held low straight through a brown-out. The bench keeps both strobes low across the dip and recovery, and confirms that writes stay blocked until a strobe returns high.

// File: rtl/supply_guard_pkg.sv
package supply_guard_pkg;
  typedef enum logic [1:0] {
    RCL_IDLE  = 2'd0,
    RCL_ARMED = 2'd1,
    RCL_RUN   = 2'd2
  } rcl_state_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned FLAG_COUNT      = 2;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[LAST];

  initial begin
    a_min_stages : assert (STAGES >= 2);
  end
endmodule

// File: rtl/recall_ctrl.sv
module recall_ctrl
  import supply_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_sw_i,
  input  logic lo_rst_i,
  input  logic done_i,
  output logic recall_req_o,
  output logic pending_o
);
  rcl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (lo_rst_i) begin
      state_d = RCL_ARMED;
    end else begin
      unique case (state_q)
        RCL_ARMED: if (!lo_sw_i) state_d = RCL_RUN;
        RCL_RUN:   if (done_i)   state_d = RCL_IDLE;
        default:   state_d = RCL_IDLE;
      endcase
    end
  end

  // reset is treated as power-up: recall latched
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RCL_ARMED;
    else         state_q <= state_d;
  end

  assign recall_req_o = (state_q == RCL_RUN);
  assign pending_o    = (state_q != RCL_IDLE);

  p_no_launch_low_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recall_req_o && !$past(recall_req_o)) |-> !$past(lo_sw_i));

  p_hold_until_done_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recall_req_o && !done_i && !lo_rst_i) |=> recall_req_o);

  p_rearm_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rst_i |=> (pending_o && !recall_req_o));
endmodule

// File: rtl/access_gate.sv
module access_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lo_sw_i,
  input  logic recall_pend_i,
  input  logic ce_ni,
  input  logic we_ni,
  output logic write_allow_o,
  output logic store_allow_o
);
  logic access_ok;
  logic hold_q;
  logic ce_q, we_q;
  logic wr_mode, fresh_fall;

  assign access_ok  = !lo_sw_i && !recall_pend_i;
  assign wr_mode    = !ce_ni && !we_ni;
  assign fresh_fall = (ce_q && !ce_ni) || (we_q && !we_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      we_q   <= 1'b1;
      hold_q <= 1'b1;
    end else begin
      ce_q <= ce_ni;
      we_q <= we_ni;
      if (!access_ok)                   hold_q <= 1'b1;
      else if (!wr_mode || fresh_fall)  hold_q <= 1'b0;
    end
  end

  assign store_allow_o = access_ok;
  assign write_allow_o = access_ok && !hold_q;

  p_write_needs_store_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_allow_o |-> store_allow_o);

  p_stale_write_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!store_allow_o) && store_allow_o && wr_mode && !fresh_fall) |-> !write_allow_o);
endmodule

// File: rtl/supply_guard.sv
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vcc_lo_sw_i,
  input  logic vcc_lo_rst_i,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic recall_done_i,
  output logic pfail_store_o,
  output logic recall_req_o,
  output logic write_allow_o,
  output logic ext_store_allow_o
);
  logic [FLAG_COUNT-1:0] flags_s;
  logic lo_sw_s, lo_rst_s;
  logic lo_sw_d;
  logic pfail_q;
  logic recall_pend;

  flag_sync #(
    .WIDTH  (FLAG_COUNT),
    .STAGES (SYNC_STAGES),
    .RST_VAL('1)
  ) i_flag_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({vcc_lo_rst_i, vcc_lo_sw_i}),
    .q_o   (flags_s)
  );

  assign lo_sw_s  = flags_s[0];
  assign lo_rst_s = flags_s[1];

  // power-fail store request on entry below switch threshold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_sw_d <= 1'b1;
      pfail_q <= 1'b0;
    end else begin
      lo_sw_d <= lo_sw_s;
      pfail_q <= lo_sw_s && !lo_sw_d;
    end
  end

  assign pfail_store_o = pfail_q;

  recall_ctrl i_recall_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lo_sw_i     (lo_sw_s),
    .lo_rst_i    (lo_rst_s),
    .done_i      (recall_done_i),
    .recall_req_o(recall_req_o),
    .pending_o   (recall_pend)
  );

  access_gate i_access_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lo_sw_i      (lo_sw_s),
    .recall_pend_i(recall_pend),
    .ce_ni        (ce_ni),
    .we_ni        (we_ni),
    .write_allow_o(write_allow_o),
    .store_allow_o(ext_store_allow_o)
  );

  p_pfail_single_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pfail_store_o |=> !pfail_store_o);

  p_blocked_low_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_sw_s |-> (!ext_store_allow_o && !write_allow_o));

  p_no_access_in_recall_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_req_o |-> !ext_store_allow_o);
endmodule

// File: tb/test_supply_guard.sv
module test_supply_guard;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sw = 1'b1, rl = 1'b1, ce_n = 1'b1, we_n = 1'b1, done = 1'b0;
  logic pfail, rcl, wr, st;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  supply_guard i_supply_guard (
    .clk_i(clk), .rst_ni(rst_ni), .vcc_lo_sw_i(sw), .vcc_lo_rst_i(rl),
    .ce_ni(ce_n), .we_ni(we_n), .recall_done_i(done),
    .pfail_store_o(pfail), .recall_req_o(rcl),
    .write_allow_o(wr), .ext_store_allow_o(st)
  );

  typedef struct packed {
    logic sw, rl, ce_n, we_n, done;
    logic [2:0] n;
    logic rcl, wr, st;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1,1,1,1,0,3'd4, 0,0,0},  // 0  R3 armed, R1 blocked
    '{1,0,1,1,0,3'd4, 0,0,0},  // 1  R3 no launch below switch
    '{0,0,1,1,0,3'd4, 1,0,0},  // 2  R4 launch
    '{0,0,1,1,1,3'd1, 0,0,1},  // 3  R5 done
    '{0,0,1,1,0,3'd2, 0,1,1},  // 4  R5 write one edge later
    '{0,0,0,0,0,3'd2, 0,1,1},  // 5  normal write
    '{1,0,0,0,0,3'd4, 0,0,0},  // 6  R1 dip, write held low
    '{0,0,0,0,0,3'd4, 0,0,1},  // 7  R6 stale write blocked
    '{0,0,1,0,0,3'd2, 0,1,1},  // 8  R6 strobe high clears
    '{0,0,0,0,0,3'd2, 0,1,1},  // 9
    '{1,0,0,0,0,3'd4, 0,0,0},  // 10 R1
    '{0,0,0,0,0,3'd4, 0,0,1},  // 11 R6
    '{0,0,0,1,0,3'd1, 0,1,1},  // 12 R6 we high
    '{0,0,0,0,0,3'd1, 0,1,1},  // 13 R6 fresh fall
    '{1,1,1,1,0,3'd4, 0,0,0},  // 14 R3
    '{0,0,1,1,0,3'd4, 1,0,0},  // 15 R4
    '{1,1,1,1,0,3'd4, 0,0,0},  // 16 R7 abort
    '{1,0,1,1,0,3'd4, 0,0,0},  // 17 R7 still armed
    '{0,0,1,1,0,3'd4, 1,0,0},  // 18 R7 relaunch
    '{0,0,1,1,1,3'd1, 0,0,1},  // 19 R5
    '{0,0,1,1,0,3'd2, 0,1,1},  // 20 R5
    '{1,0,1,1,0,3'd4, 0,0,0},  // 21 R4 switch-only dip
    '{0,0,1,1,0,3'd4, 0,1,1},  // 22 R4 no recall
    '{0,0,1,1,1,3'd2, 0,1,1},  // 23 R5 done ignored
    '{0,0,1,1,0,3'd1, 0,1,1}   // 24
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R8 reset recall", rcl, 1'b0);
    chk("R1 reset write", wr, 1'b0);
    chk("R1 reset store", st, 1'b0);
    chk("R2 reset pfail", pfail, 1'b0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      sw = VEC[i].sw; rl = VEC[i].rl; ce_n = VEC[i].ce_n;
      we_n = VEC[i].we_n; done = VEC[i].done;
      tick(int'(VEC[i].n));
      chk($sformatf("vec%0d recall R4", i), rcl, VEC[i].rcl);
      chk($sformatf("vec%0d write R6", i), wr, VEC[i].wr);
      chk($sformatf("vec%0d store R1", i), st, VEC[i].st);
      chk($sformatf("vec%0d pfail R2", i), pfail, 1'b0);
    end

    // R2: pulse timing on entry below switch
    sw = 1'b1;
    tick(2);
    chk("R2 pfail before third edge", pfail, 1'b0);
    tick(1);
    chk("R2 pfail at third edge", pfail, 1'b1);
    tick(1);
    chk("R2 pfail single cycle", pfail, 1'b0);
    sw = 1'b0;
    tick(4);

    // R8: reset mid-run re-arms recall, launch after third edge
    @(negedge clk);
    rst_ni = 1'b0;
    tick(1);
    chk("R8 reset clears store", st, 1'b0);
    rst_ni = 1'b1;
    tick(2);
    chk("R8 no recall at second edge", rcl, 1'b0);
    tick(1);
    chk("R8 recall at third edge", rcl, 1'b1);
    chk("R2 no pulse after reset", pfail, 1'b0);
    done = 1'b1;
    tick(1);
    done = 1'b0;
    chk("R5 done clears", rcl, 1'b0);
    chk("R5 store after done", st, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule